// File: doc/BRIEF.md
# Playback Block Counter and Completion Interrupt

This block meters the bytes that a playback transfer engine hands to the audio path and signals when a programmed block has been fully delivered. Software loads a 16-bit block length split across an upper and a lower byte. The block scales that length into a byte count by a left shift. The shift follows from the sample format code and the stereo bit, because one programmed unit is one sample frame. Every transfer burst the engine offers is granted in full, or clipped so the running count lands exactly on the terminal value.

When the terminal value is reached, the block raises a registered interrupt level, sets an interrupt status flag and a separate playback-done flag, and restarts its count from zero. Two register actions clear these flags. A write to the status location drops the line and both flags. A write to the flag register sets the playback-done flag to the written value, and a 1-to-0 transition also drops the line and the status flag. A small two-state controller (`ST_IDLE`, `ST_RUN`) follows the playback enable. The move `ST_IDLE -> ST_RUN` happens on the clock edge that sees `play_en` high, and it begins a block from a zero count. The move `ST_RUN -> ST_IDLE` happens on the edge that sees `play_en` low, and it withdraws the transfer request. While the counting enable is low, transfers are not limited and nothing is counted.

Top module: `pbk_block_irq`

## Requirements
- R1: After reset `irq`, `int_flag`, `pi_flag` and `dma_req` are 0 and `xfer_grant` is 0.
- R2: The terminal byte count is `{base_hi, base_lo}` shifted left by S. For format codes 2 and 6 (16-bit linear), S = 1 + `stereo`. For every other code (0 = 8-bit unsigned, 1 = mu-law, 3 = A-law), S = `stereo`.
- R3: In `ST_RUN` with `cnt_en` high, `xfer_grant` = min(`xfer_len`, terminal − count) combinationally while `xfer_valid` is high, and the count advances by the grant at the clock edge.
- R4: When a grant makes the count equal the terminal value, `irq`, `int_flag` and `pi_flag` are 1 after that edge and the count returns to 0.
- R5: A `stat_wr` pulse clears `irq`, `int_flag` and `pi_flag` at the next edge.
- R6: A `flag_wr` pulse loads `pi_flag` with `flag_pi`. If `pi_flag` was 1 and `flag_pi` is 0, `irq` and `int_flag` also clear. Writing 1 never raises `irq`.
- R7: With `cnt_en` low, `xfer_grant` equals `xfer_len`, the count is held, and no interrupt occurs.
- R8: `dma_req` is 1 exactly while in `ST_RUN`, which is entered one edge after `play_en` rises and left one edge after it falls. Outside `ST_RUN` `xfer_grant` is 0, and every entry starts from a zero count.
- R9: With a terminal value of 0 and `cnt_en` high, `xfer_grant` is 0 and no interrupt is raised.
- R10: If a completion and a clear event occur in the same cycle, the completion wins and all three flags end set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| play_en | input | 1 | Playback enable |
| cnt_en | input | 1 | Block counting and interrupt enable |
| base_hi | input | 8 | Upper byte of block length |
| base_lo | input | 8 | Lower byte of block length |
| fmt_code | input | 3 | Sample format code |
| stereo | input | 1 | 1 = two channels |
| xfer_valid | input | 1 | Transfer engine offers a burst |
| xfer_len | input | 8 | Bytes offered in the burst |
| xfer_grant | output | 8 | Bytes accepted this cycle |
| dma_req | output | 1 | Transfer request, high while running |
| stat_wr | input | 1 | Write strobe to the status location |
| flag_wr | input | 1 | Write strobe to the flag register |
| flag_pi | input | 1 | Playback-done value written with `flag_wr` |
| irq | output | 1 | Interrupt level |
| int_flag | output | 1 | Interrupt status flag |
| pi_flag | output | 1 | Playback-done flag |

## Verification
The bench drives bursts that straddle the terminal count. A design that failed to clip would overrun the block and never see equality, so the interrupt would never fire. Each format and stereo combination is run against its own block size, which shows up a shift table off by one as an early or late interrupt. Clears are tried through both register actions, including a flag write of 1 that must not raise the line and a clear in the same cycle as a completion, where a wrong priority loses the event. Playback is stopped and restarted mid-block and the counting enable is dropped, which catches a count that is not zeroed or that keeps running while disabled.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
    localparam int BASE_W    = 16;
    localparam int MAX_SHIFT = 2;
    localparam int TERM_W    = BASE_W + MAX_SHIFT;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } play_st_e;

    // 16-bit linear formats carry two bytes per channel per frame
    function automatic logic [1:0] frame_shift(input logic [2:0] code, input logic two_ch);
        logic wide;
        wide = (code == 3'd2) || (code == 3'd6);
        return wide ? (2'd1 + {1'b0, two_ch}) : {1'b0, two_ch};
    endfunction
endpackage

// File: rtl/pbk_term_calc.sv
module pbk_term_calc
    import pbk_pkg::*;
(
    input  logic [7:0]        base_hi,
    input  logic [7:0]        base_lo,
    input  logic [2:0]        fmt_code,
    input  logic              stereo,
    output logic [TERM_W-1:0] term
);
    logic [1:0]        sh;
    logic [TERM_W-1:0] base_ext;

    always_comb begin
        sh       = frame_shift(fmt_code, stereo);
        base_ext = TERM_W'({base_hi, base_lo});
        term     = base_ext << sh;
    end
endmodule

// File: rtl/pbk_byte_counter.sv
module pbk_byte_counter
    import pbk_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              count_on,
    input  logic              xfer_valid,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [TERM_W-1:0] term,
    output logic [LEN_W-1:0]  grant,
    output logic              done
);
    logic [TERM_W-1:0] count_q;
    logic [TERM_W-1:0] remain;
    logic [TERM_W-1:0] len_ext;
    logic [TERM_W-1:0] sum;

    always_comb begin
        remain  = (count_q < term) ? (term - count_q) : '0;
        len_ext = TERM_W'(xfer_len);
        grant   = '0;
        if (run && xfer_valid) begin
            if (!count_on)
                grant = xfer_len;
            else if (len_ext <= remain)
                grant = xfer_len;
            else
                grant = remain[LEN_W-1:0];
        end
        sum  = count_q + TERM_W'(grant);
        done = run && count_on && (grant != '0) && (sum == term);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (!run)
            count_q <= '0;
        else if (count_on && grant != '0)
            count_q <= done ? '0 : sum;
    end

    // R3
    grant_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant <= xfer_len);

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (count_q == '0));
endmodule

// File: rtl/pbk_irq_flags.sv
module pbk_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic stat_wr,
    input  logic flag_wr,
    input  logic flag_pi,
    output logic irq,
    output logic int_flag,
    output logic pi_flag
);
    logic pi_drop;

    always_comb pi_drop = flag_wr && pi_flag && !flag_pi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            int_flag <= 1'b0;
            pi_flag  <= 1'b0;
        end else if (done) begin
            irq      <= 1'b1;
            int_flag <= 1'b1;
            pi_flag  <= 1'b1;
        end else if (stat_wr) begin
            irq      <= 1'b0;
            int_flag <= 1'b0;
            pi_flag  <= 1'b0;
        end else begin
            if (flag_wr)
                pi_flag <= flag_pi;
            if (pi_drop) begin
                irq      <= 1'b0;
                int_flag <= 1'b0;
            end
        end
    end

    // R4
    done_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (irq && int_flag && pi_flag));

    // R5
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !done) |=> (!irq && !int_flag && !pi_flag));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pi_drop && !stat_wr && !done) |=> (!irq && !int_flag));

    // R6
    no_self_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !irq) |=> !irq);
endmodule

// File: rtl/pbk_block_irq.sv
module pbk_block_irq
    import pbk_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             play_en,
    input  logic             cnt_en,
    input  logic [7:0]       base_hi,
    input  logic [7:0]       base_lo,
    input  logic [2:0]       fmt_code,
    input  logic             stereo,
    input  logic             xfer_valid,
    input  logic [LEN_W-1:0] xfer_len,
    output logic [LEN_W-1:0] xfer_grant,
    output logic             dma_req,
    input  logic             stat_wr,
    input  logic             flag_wr,
    input  logic             flag_pi,
    output logic             irq,
    output logic             int_flag,
    output logic             pi_flag
);
    play_st_e          state_q, state_d;
    logic [TERM_W-1:0] term;
    logic              running;
    logic              blk_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (play_en)  state_d = ST_RUN;
            ST_RUN:  if (!play_en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUN);
        dma_req = running;
    end

    pbk_term_calc u_term (
        .base_hi  (base_hi),
        .base_lo  (base_lo),
        .fmt_code (fmt_code),
        .stereo   (stereo),
        .term     (term)
    );

    pbk_byte_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (running),
        .count_on   (cnt_en),
        .xfer_valid (xfer_valid),
        .xfer_len   (xfer_len),
        .term       (term),
        .grant      (xfer_grant),
        .done       (blk_done)
    );

    pbk_irq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (blk_done),
        .stat_wr  (stat_wr),
        .flag_wr  (flag_wr),
        .flag_pi  (flag_pi),
        .irq      (irq),
        .int_flag (int_flag),
        .pi_flag  (pi_flag)
    );

    // R8
    stop_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> !dma_req);

    // R8
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        play_en |=> dma_req);

    // R8
    idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req |-> (xfer_grant == '0));

    // R7
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && dma_req && xfer_valid) |-> (xfer_grant == xfer_len));
endmodule

// File: tb/sim_pbk_block_irq.sv
`timescale 1ns/1ps
module sim_pbk_block_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       play_en = 0, cnt_en = 0, stereo = 0;
    logic [7:0] base_hi = 0, base_lo = 0;
    logic [2:0] fmt_code = 0;
    logic       xfer_valid = 0;
    logic [7:0] xfer_len = 0;
    logic [7:0] xfer_grant;
    logic       dma_req, stat_wr = 0, flag_wr = 0, flag_pi = 0;
    logic       irq, int_flag, pi_flag;
    int         n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    pbk_block_irq u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive a burst at a negedge, return grant, finish at next negedge
    task automatic burst(input int len, output int g);
        xfer_valid = 1; xfer_len = 8'(len);
        #1 g = xfer_grant;
        @(negedge clk);
        xfer_valid = 0;
    endtask

    task automatic setup(input int base, input int fmt, input bit st, input bit ien);
        play_en = 0;
        @(negedge clk);
        base_hi = 8'(base >> 8); base_lo = 8'(base); fmt_code = 3'(fmt); stereo = st; cnt_en = ien;
        stat_wr = 1; @(negedge clk); stat_wr = 0;
        play_en = 1; @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 irq", irq, 0); chk("R1 int", int_flag, 0); chk("R1 pi", pi_flag, 0);
        chk("R1 req", dma_req, 0); chk("R1 grant", xfer_grant, 0);
    endtask

    task automatic t_mono8();
        int g;
        setup(3, 0, 0, 1);
        chk("R8 req", dma_req, 1);
        burst(1, g); chk("R3 g1", g, 1); chk("R4 early", irq, 0);
        burst(1, g); chk("R4 early2", irq, 0);
        burst(1, g); chk("R3 g3", g, 1);
        chk("R4 irq", irq, 1); chk("R4 int", int_flag, 1); chk("R4 pi", pi_flag, 1);
        burst(9, g); chk("R4 wrap", g, 3);
        stat_wr = 1; @(negedge clk); stat_wr = 0;
        chk("R5 irq", irq, 0); chk("R5 int", int_flag, 0); chk("R5 pi", pi_flag, 0);
    endtask

    task automatic t_stereo16();
        int g;
        setup(2, 2, 1, 1);
        burst(5, g); chk("R2 s16 g1", g, 5); chk("R4 none", irq, 0);
        burst(5, g); chk("R3 clip", g, 3); chk("R4 clip irq", irq, 1);
        flag_wr = 1; flag_pi = 0; @(negedge clk); flag_wr = 0;
        chk("R6 irq", irq, 0); chk("R6 int", int_flag, 0); chk("R6 pi", pi_flag, 0);
        flag_wr = 1; flag_pi = 1; @(negedge clk); flag_wr = 0;
        chk("R6 pi set", pi_flag, 1); chk("R6 no irq", irq, 0);
    endtask

    task automatic t_formats();
        int g;
        setup(2, 1, 1, 1);
        burst(9, g); chk("R2 mulaw st", g, 4); chk("R4 mulaw", irq, 1);
        setup(3, 6, 0, 1);
        burst(20, g); chk("R2 s16be mono", g, 6);
        setup(5, 3, 0, 1);
        burst(20, g); chk("R2 alaw mono", g, 5);
    endtask

    task automatic t_no_count();
        int g;
        setup(4, 0, 0, 0);
        burst(100, g); chk("R7 full", g, 100); chk("R7 no irq", irq, 0);
        cnt_en = 1;
        burst(100, g); chk("R7 held", g, 4);
    endtask

    task automatic t_restart();
        int g;
        setup(10, 0, 0, 1);
        burst(6, g);
        play_en = 0; @(negedge clk);
        chk("R8 req off", dma_req, 0);
        burst(6, g); chk("R8 idle grant", g, 0);
        play_en = 1; @(negedge clk);
        burst(20, g); chk("R8 restart", g, 10);
    endtask

    task automatic t_zero();
        int g;
        setup(0, 2, 1, 1);
        burst(8, g); chk("R9 grant", g, 0); chk("R9 irq", irq, 0);
    endtask

    task automatic t_collide();
        int g;
        setup(2, 0, 0, 1);
        stat_wr = 1; flag_wr = 1; flag_pi = 0;
        burst(2, g);
        stat_wr = 0; flag_wr = 0;
        chk("R10 irq", irq, 1); chk("R10 int", int_flag, 1); chk("R10 pi", pi_flag, 1);
    endtask

    initial begin
        #2000000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); t_reset();
        @(negedge clk); rst_n = 1; @(negedge clk);
        t_reset();
        t_mono8();
        t_stereo16();
        t_formats();
        t_no_count();
        t_restart();
        t_zero();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule